// File: doc/BRIEF.md
# FIFO-Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line. Software writes bytes into a transmit queue through a simple write strobe. When transmission is enabled, a shifter pulls the bytes out one at a time and sends each as a 10-bit frame: a start bit, eight data bits with the least significant bit first, and a stop bit. All bit timing comes from a sample pulse that runs at sixteen times the bit rate. That pulse comes either from an internal programmable divider or from rising edges on an external clock pin, which is synchronised to the system clock first. In internal mode the block can also drive a clock pin at the sample rate.

Dropping the enable abandons the character being sent and returns the line to idle at once. The queue and the status flags keep their values. Bytes still waiting go out when the enable returns, unless the queue is flushed first. Software is expected to flush before re-enabling. A transmit-end flag reports that every queued byte has finished its stop bit.

Top module: `fifo_serial_tx`

## Requirements
- R1: Each byte is sent as one start bit (0), eight data bits starting with bit 0, and one stop bit (1). The line is 1 whenever no frame is in progress.
- R2: The line changes only on sample pulses, and each bit lasts 16 sample periods. With the internal source, one sample period is `baud_div`+1 clock cycles.
- R3: With `use_ext_clk` set, each rising edge of `ext_clk_in` counts as one sample period. An external clock at 16 times the bit rate therefore sets the bit rate.
- R4: With the internal source selected, `baud_div` ≥ 1 and `clk_out_en` set, `clk_pin_out` is a square wave of period `baud_div`+1 cycles. In every other case it is held at 0.
- R5: Queued bytes leave in the order they were written, each frame following the previous one with no idle bit time in between.
- R6: The queue holds `FIFO_DEPTH` bytes. A write while it is full is dropped and sets `overflow`, which stays set until a flush.
- R7: `tx_done` is 1 after reset. A write while `tx_enable` is set clears it. It is set again when a stop bit ends and the queue is empty.
- R8: When `tx_enable` falls in the middle of a frame, the line is 1 from the next clock on, and the rest of that character is never sent.
- R9: Clearing `tx_enable` leaves the queue contents and `tx_done` unchanged. After re-enabling, the bytes that were still waiting are sent.
- R10: A one-cycle `fifo_flush` pulse empties the queue and clears `overflow`. Nothing that was queued before the flush is sent afterwards.
- R11: Bytes written while `tx_enable` is clear are held in the queue without being sent, and the write leaves `tx_done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe: pushes `wr_data` into the queue |
| wr_data | input | 8 | Byte to queue |
| tx_enable | input | 1 | Transmit enable; clearing it aborts the frame in progress |
| fifo_flush | input | 1 | Empties the queue and clears `overflow` |
| use_ext_clk | input | 1 | 1 selects the external sample clock, 0 the internal divider |
| clk_out_en | input | 1 | Drives the sample clock on `clk_pin_out` in internal mode |
| baud_div | input | DIV_W | Internal divider: sample period is `baud_div`+1 cycles |
| ext_clk_in | input | 1 | External sample clock, asynchronous |
| tx_line | output | 1 | Serial output, idle high |
| clk_pin_out | output | 1 | Sample clock output |
| tx_done | output | 1 | Transmit-end flag |
| overflow | output | 1 | Sticky flag for a write dropped because the queue was full |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and `DIV_W` = 6, and runs the divider at `baud_div` = 3, so one bit lasts 64 cycles. The shallow queue fills after four writes, which brings the dropped-write and sticky overflow cases within a few cycles. The short bit time fits several full frames, an aborted frame, and a run on an external clock with a 6-cycle period into a short run. The bench also times a 9-bit low pulse to check the sixteen-samples-per-bit rule.

// File: rtl/fst_pkg.sv
package fst_pkg;
  localparam int FRAME_BITS = 10;
  localparam int SUBTICKS   = 16;
  typedef enum logic [1:0] {SH_IDLE, SH_LOAD, SH_SEND} sh_state_t;
endpackage

// File: rtl/fst_tick_source.sv
module fst_tick_source #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_ext,
  input  logic             clk_out_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             ext_clk_in,
  output logic             tick,
  output logic             clk_pin_out
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   half;
  logic [1:0]       sync_q;
  logic             prev_q;
  logic             int_wrap;

  assign int_wrap = (cnt >= baud_div);
  assign half     = ({1'b0, baud_div} + {{DIV_W{1'b0}}, 1'b1}) >> 1;

  always_ff @(posedge clk) begin
    if (rst || use_ext)  cnt <= '0;
    else if (int_wrap)   cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= 2'b00;
      prev_q      <= 1'b0;
      tick        <= 1'b0;
      clk_pin_out <= 1'b0;
    end else begin
      sync_q      <= {sync_q[0], ext_clk_in};
      prev_q      <= sync_q[1];
      tick        <= use_ext ? (sync_q[1] & ~prev_q) : int_wrap;
      clk_pin_out <= !use_ext && clk_out_en && ({1'b0, cnt} < half);
    end
  end

  assert_ext_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
    (use_ext && $past(use_ext) && tick) |=> !tick);
  assert_clk_out_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (!clk_out_en || use_ext) |=> !clk_pin_out);
endmodule

// File: rtl/fst_tx_fifo.sv
module fst_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         push_ok, pop_ok;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW-1:0] == rptr[AW-1:0]) && (wptr[AW] != rptr[AW]);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr[AW-1:0]] <= push_data;
    if (pop_ok)  pop_data <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)        overflow <= 1'b0;
    else if (push && full)   overflow <= 1'b1;
  end

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (full && $stable(wptr)));
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (overflow && !flush) |=> overflow);
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !overflow));
endmodule

// File: rtl/fst_frame_shifter.sv
module fst_frame_shifter
  import fst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_enable,
  input  logic       tick,
  input  logic       fifo_empty,
  input  logic [7:0] pop_data,
  output logic       pop,
  output logic       line,
  output logic       frame_end
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam int SUB_W = $clog2(SUBTICKS);

  sh_state_t              state;
  logic [FRAME_BITS-1:0]  shreg;
  logic [IDX_W-1:0]       idx;
  logic [SUB_W-1:0]       sub;

  assign pop = (state == SH_IDLE) && tx_enable && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst || !tx_enable) begin
      state     <= SH_IDLE;
      shreg     <= '1;
      idx       <= '0;
      sub       <= '0;
      line      <= 1'b1;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      case (state)
        SH_IDLE: begin
          line <= 1'b1;
          if (!fifo_empty) state <= SH_LOAD;
        end
        SH_LOAD: begin
          shreg <= {1'b1, pop_data, 1'b0};
          line  <= 1'b0;
          idx   <= '0;
          sub   <= '0;
          state <= SH_SEND;
        end
        default: begin
          if (tick) begin
            if (sub == SUB_W'(SUBTICKS - 1)) begin
              sub <= '0;
              if (idx == IDX_W'(FRAME_BITS - 1)) begin
                state     <= SH_IDLE;
                frame_end <= 1'b1;
                line      <= 1'b1;
              end else begin
                idx   <= idx + 1'b1;
                shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                line  <= shreg[1];
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !tx_enable |=> (line && state == SH_IDLE));
  assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_enable && state == SH_SEND && !tick) |=> ($stable(line) && $stable(sub)));
endmodule

// File: rtl/fifo_serial_tx.sv
module fifo_serial_tx #(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             tx_enable,
  input  logic             fifo_flush,
  input  logic             use_ext_clk,
  input  logic             clk_out_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             ext_clk_in,
  output logic             tx_line,
  output logic             clk_pin_out,
  output logic             tx_done,
  output logic             overflow
);
  logic       tick, pop, empty, full, frame_end;
  logic [7:0] pop_data;

  fst_tick_source #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .use_ext(use_ext_clk), .clk_out_en(clk_out_en),
    .baud_div(baud_div), .ext_clk_in(ext_clk_in), .tick(tick),
    .clk_pin_out(clk_pin_out));

  fst_tx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(fifo_flush), .push(wr_en),
    .push_data(wr_data), .pop(pop), .pop_data(pop_data), .empty(empty),
    .full(full), .overflow(overflow));

  fst_frame_shifter u_shift (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .tick(tick),
    .fifo_empty(empty), .pop_data(pop_data), .pop(pop), .line(tx_line),
    .frame_end(frame_end));

  always_ff @(posedge clk) begin
    if (rst)                         tx_done <= 1'b1;
    else if (wr_en && tx_enable)     tx_done <= 1'b0;
    else if (frame_end && empty)     tx_done <= 1'b1;
  end

  assert_done_clear_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_enable) |=> !tx_done);
  assert_done_rise_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> (tx_line && empty));
  assert_done_held_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!tx_enable && !frame_end) |=> $stable(tx_done));
endmodule

// File: tb/fifo_serial_tx_test.sv
module fifo_serial_tx_test;
  localparam int DEPTH = 4;
  localparam int DW    = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, tx_enable = 1'b0, fifo_flush = 1'b0;
  logic use_ext_clk = 1'b0, clk_out_en = 1'b0, ext_clk_in = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [DW-1:0] baud_div = 6'd3;
  logic tx_line, clk_pin_out, tx_done, overflow;

  int vectors = 0, fails = 0;
  int bit_cyc = 64;
  bit mon_on = 1'b0, ext_run = 1'b0;
  logic [7:0] sb[$];

  fifo_serial_tx #(.FIFO_DEPTH(DEPTH), .DIV_W(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .fifo_flush(fifo_flush), .use_ext_clk(use_ext_clk),
    .clk_out_en(clk_out_en), .baud_div(baud_div), .ext_clk_in(ext_clk_in),
    .tx_line(tx_line), .clk_pin_out(clk_pin_out), .tx_done(tx_done),
    .overflow(overflow));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input bit expect_out);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    if (expect_out) sb.push_back(b);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic drain(input string req);
    int n;
    n = 0;
    while (!(sb.size() == 0 && tx_done) && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(n < 20000, req, "drain finished", n, 0);
  endtask

  task automatic hold_high(input int cyc, input string req);
    int lows;
    lows = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (!tx_line) lows++;
    end
    chk(lows == 0, req, "line low cycles while idle", lows, 0);
  endtask

  // external sample clock, 6-cycle period
  initial forever begin
    repeat (3) @(negedge clk);
    if (ext_run) ext_clk_in = ~ext_clk_in;
  end

  // monitor: decodes frames and compares with the scoreboard
  initial begin
    logic prev;
    logic [7:0] got, exp;
    logic ok_start, ok_stop;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_on && prev && !tx_line) begin
        repeat (bit_cyc / 2 - 1) @(negedge clk);
        ok_start = !tx_line;
        for (int i = 0; i < 8; i++) begin
          repeat (bit_cyc) @(negedge clk);
          got[i] = tx_line;
        end
        repeat (bit_cyc) @(negedge clk);
        ok_stop = tx_line;
        if (sb.size() == 0) begin
          chk(1'b0, "R1", "unexpected frame", int'(got), -1);
        end else begin
          exp = sb.pop_front();
          chk(got == exp, "R1", "frame data (order R5)", int'(got), int'(exp));
          chk(ok_start && ok_stop, "R1", "start/stop levels",
              int'({ok_start, ok_stop}), 3);
        end
      end
      prev = tx_line;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int t, lowlen, r1, r2, highs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1, "R1", "reset line", tx_line, 1);
    chk(tx_done == 1'b1, "R7", "reset tx_done", tx_done, 1);
    chk(overflow == 1'b0, "R6", "reset overflow", overflow, 0);

    // R1 R5 R7: internal divider, back-to-back frames
    mon_on = 1'b1; tx_enable = 1'b1;
    push_byte(8'hA5, 1'b1);
    chk(tx_done == 1'b0, "R7", "tx_done after write", tx_done, 0);
    push_byte(8'h3C, 1'b1);
    push_byte(8'h01, 1'b1);
    push_byte(8'hFF, 1'b1);
    drain("R5");
    chk(tx_line == 1'b1, "R7", "line at done", tx_line, 1);

    // R2: byte 0x00 gives 9 low bits = 144 sample periods of 4 cycles
    push_byte(8'h00, 1'b1);
    t = 0;
    while (tx_line && t < 1000) begin @(negedge clk); t++; end
    lowlen = 0;
    while (!tx_line && lowlen < 2000) begin @(negedge clk); lowlen++; end
    chk(lowlen >= 570 && lowlen <= 578, "R2", "low run for 0x00", lowlen, 576);
    drain("R2");

    // R4: clock output
    clk_out_en = 1'b1;
    t = 0; r1 = -1; r2 = -1;
    begin
      logic pv;
      pv = clk_pin_out;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!pv && clk_pin_out) begin
          if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
        end
        pv = clk_pin_out;
      end
    end
    chk(r1 >= 0 && r2 - r1 == 4, "R4", "clock out period", r2 - r1, 4);
    clk_out_en = 1'b0;
    @(negedge clk); @(negedge clk);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (clk_pin_out) highs++; end
    chk(highs == 0, "R4", "clock out disabled", highs, 0);

    // R11 R6: writes while disabled, overflow
    tx_enable = 1'b0;
    push_byte(8'h11, 1'b1);
    push_byte(8'h22, 1'b1);
    push_byte(8'h33, 1'b1);
    push_byte(8'h44, 1'b1);
    push_byte(8'h55, 1'b0);
    push_byte(8'h66, 1'b0);
    chk(overflow == 1'b1, "R6", "overflow after full writes", overflow, 1);
    chk(tx_done == 1'b1, "R11", "tx_done on disabled write", tx_done, 1);
    hold_high(200, "R11");
    tx_enable = 1'b1;
    drain("R6");
    chk(overflow == 1'b1, "R6", "overflow sticky", overflow, 1);

    // R10: flush
    @(negedge clk); fifo_flush = 1'b1;
    @(negedge clk); fifo_flush = 1'b0;
    chk(overflow == 1'b0, "R10", "overflow after flush", overflow, 0);
    tx_enable = 1'b0;
    push_byte(8'h99, 1'b0);
    push_byte(8'h98, 1'b0);
    @(negedge clk); fifo_flush = 1'b1;
    @(negedge clk); fifo_flush = 1'b0;
    tx_enable = 1'b1;
    hold_high(300, "R10");
    chk(tx_done == 1'b1, "R10", "tx_done after flush", tx_done, 1);

    // R8 R9: abort mid frame
    mon_on = 1'b0;
    push_byte(8'h55, 1'b0);
    push_byte(8'h81, 1'b0);
    push_byte(8'h7E, 1'b0);
    t = 0;
    while (tx_line && t < 1000) begin @(negedge clk); t++; end
    repeat (5 * bit_cyc) @(negedge clk);
    tx_enable = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1, "R8", "line after disable", tx_line, 1);
    hold_high(300, "R8");
    chk(tx_done == 1'b0, "R9", "tx_done kept while off", tx_done, 0);
    sb.push_back(8'h81); sb.push_back(8'h7E);
    mon_on = 1'b1;
    tx_enable = 1'b1;
    drain("R9");

    // R3: external sample clock, 6-cycle period -> 96 cycles per bit
    tx_enable = 1'b0;
    use_ext_clk = 1'b1; ext_run = 1'b1; bit_cyc = 96;
    repeat (20) @(negedge clk);
    tx_enable = 1'b1;
    push_byte(8'hC3, 1'b1);
    push_byte(8'h5A, 1'b1);
    drain("R3");
    chk(sb.size() == 0, "R3", "scoreboard empty", sb.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule